// File: doc/BRIEF.md
# Multi-Source Reset Domain Controller

This block sits between a peripheral device's register file and its functional sections. It turns three reset sources into one reset level per section. Software writes two of the sources into a system control register: a software reset bit and a core reset bit. The host sets the third source, a card soft reset bit, in the card configuration option register. A hardware reset input asserts every domain. Each register source drives its own, partly overlapping set of domains. One group of system register bits is reset only by hardware, so it survives all three register sources.

Every domain reset asserts on the clock edge after its request appears. It is released through a two-stage synchronizer, so a domain stays in reset for two clocks after its last request has gone. The block also gives the default values that a few configuration bit-fields take while their reset is active. It keeps a sticky warning that is set when software reset is raised while core reset is not held and the embedded controller is not halted.

Domain index map for `dom_rst`:
- 0: embedded controller
- 1: timer/interface logic
- 2: sleep state machine
- 3: memory bus arbiter
- 4: plug-and-play logic
- 5: card configuration registers
- 6: hardware-only system register group
- 7: general system registers
- 8: miscellaneous registers
- 9: flash/SRAM wait-state settings
- 10: miscellaneous bit-field force

Top module: `reset_domain_ctl`

## Requirements
- R1: While `hw_rst_n` is low, every `dom_rst` bit is 1 and `swr_q`, `cor_q`, `csr_q` and `seq_warn` are 0. Two clocks after `hw_rst_n` rises with no register source set, every `dom_rst` bit is 0.
- R2: The software reset bit (control data bit 7) asserts only domains 2, 3 and 9.
- R3: The core reset bit (control data bit 6) asserts only domains 0, 1 and 10.
- R4: The card soft reset bit (configuration data bit 7) asserts every domain except domain 6. Domain 6 is asserted only by hardware reset.
- R5: A domain reset rises on the clock edge after a source bit that covers it reads 1. It falls two clock edges after the last such source reads 0, so a source bit held for a single clock gives a reset pulse of exactly two clocks.
- R6: The embedded controller reset (domain 0) stays asserted for as long as the core reset bit reads 1.
- R7: Writing software reset from 0 to 1 while core reset reads 0 and `ctrl_halted` is 0 sets `seq_warn`. The flag then holds until hardware reset.
- R8: `seq_warn` stays 0 when software reset is raised while core reset already reads 1, or while `ctrl_halted` is 1.
- R9: While the card soft reset bit reads 1, the core reset bit is forced to 0 and control writes to it are ignored. The software reset bit and the card soft reset bit keep their written values.
- R10: `fld_a_dflt` and `fld_b_dflt` both read 2'b11.
- R11: A strobed write updates the matching register bits on the next clock edge. Without a strobe the bits hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous assertion |
| ctl_wr | input | 1 | Write strobe for the system control register |
| ctl_wdata | input | 8 | Control write data (bit 7 software reset, bit 6 core reset) |
| cfg_wr | input | 1 | Write strobe for the card configuration option register |
| cfg_wdata | input | 8 | Configuration write data (bit 7 card soft reset) |
| ctrl_halted | input | 1 | Embedded controller is halted |
| dom_rst | output | 11 | Per-domain reset levels, active high |
| fld_a_dflt | output | 2 | Default value of the first forced bit-field |
| fld_b_dflt | output | 2 | Default value of the second forced bit-field |
| swr_q | output | 1 | Current software reset bit |
| cor_q | output | 1 | Current core reset bit |
| csr_q | output | 1 | Current card soft reset bit |
| seq_warn | output | 1 | Sticky reset-sequence warning |

## Verification
The case hardest to reach is a software reset bit that is high for exactly one clock. It needs two control writes on back-to-back edges, and the output window that results is only two cycles wide. The bench issues those writes from tasks that move the strobe on consecutive falling edges, then counts the reset cycles of the affected domain. It also steps through the sequences where core reset is already held, where the controller is halted, and where a card soft reset overrides a held core reset. These sequences separate the warning conditions and show the override of core reset, while a behavioural model is compared with the outputs on every clock.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  // domain indices
  localparam int D_CTRL    = 0;
  localparam int D_TMR     = 1;
  localparam int D_SLEEP   = 2;
  localparam int D_ARB     = 3;
  localparam int D_PNP     = 4;
  localparam int D_CARDCFG = 5;
  localparam int D_SYSKEEP = 6;
  localparam int D_SYSGEN  = 7;
  localparam int D_MISC    = 8;
  localparam int D_WAIT    = 9;
  localparam int D_MFLD    = 10;
  localparam int NDOM      = 11;

  // source vector bit positions
  localparam int S_SWR  = 0;
  localparam int S_COR  = 1;
  localparam int S_CSR  = 2;
  localparam int NSRC   = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  // which register sources reach a domain (hardware reset reaches all)
  function automatic src_vec_t dom_mask(input int d);
    src_vec_t m;
    m = '0;
    case (d)
      D_CTRL, D_TMR, D_MFLD: begin
        m[S_COR] = 1'b1;
        m[S_CSR] = 1'b1;
      end
      D_SLEEP, D_ARB, D_WAIT: begin
        m[S_SWR] = 1'b1;
        m[S_CSR] = 1'b1;
      end
      D_PNP, D_CARDCFG, D_SYSGEN, D_MISC: m[S_CSR] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic dom_hit(input src_vec_t mask, input src_vec_t src);
    return |(mask & src);
  endfunction

endpackage

// File: rtl/rdc_src_regs.sv
module rdc_src_regs #(
  parameter int DW      = 8,
  parameter int SWR_BIT = 7,
  parameter int COR_BIT = 6,
  parameter int CSR_BIT = 7
) (
  input  logic          clk,
  input  logic          hw_rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ctrl_halted,
  output logic          swr_q,
  output logic          cor_q,
  output logic          csr_q,
  output logic          swr_set_evt,
  output logic          seq_warn
);

  logic swr_d, cor_d, csr_d, warn_hit;
  logic unused_wdata;

  assign unused_wdata = ^{ctl_wdata, cfg_wdata};

  // a control write raising software reset from 0
  assign swr_set_evt = ctl_wr && ctl_wdata[SWR_BIT] && !swr_q;
  assign warn_hit    = swr_set_evt && !cor_q && !ctrl_halted;

  always_comb begin
    swr_d = ctl_wr ? ctl_wdata[SWR_BIT] : swr_q;
    csr_d = cfg_wr ? cfg_wdata[CSR_BIT] : csr_q;
    if (csr_q)
      cor_d = 1'b0;
    else if (ctl_wr)
      cor_d = ctl_wdata[COR_BIT];
    else
      cor_d = cor_q;
  end

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      swr_q    <= 1'b0;
      cor_q    <= 1'b0;
      csr_q    <= 1'b0;
      seq_warn <= 1'b0;
    end else begin
      swr_q    <= swr_d;
      cor_q    <= cor_d;
      csr_q    <= csr_d;
      seq_warn <= seq_warn | warn_hit;
    end
  end

endmodule

// File: rtl/rdc_dom_map.sv
module rdc_dom_map
  import rdc_pkg::*;
(
  input  src_vec_t        src,
  output logic [NDOM-1:0] dom_req
);

  for (genvar d = 0; d < NDOM; d++) begin : g_map
    localparam src_vec_t MASK = dom_mask(d);
    assign dom_req[d] = dom_hit(MASK, src);
  end

endmodule

// File: rtl/rdc_rst_sync.sv
module rdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic req,
  output logic rst_out
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)
      sh <= '1;
    else if (req)
      sh <= '1;
    else
      sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_out = sh[STAGES-1];

endmodule

// File: rtl/reset_domain_ctl.sv
module reset_domain_ctl
  import rdc_pkg::*;
#(
  parameter int              DW          = 8,
  parameter int              SWR_BIT     = 7,
  parameter int              COR_BIT     = 6,
  parameter int              CSR_BIT     = 7,
  parameter int              SYNC_STAGES = 2,
  parameter int              FLD_W       = 2,
  parameter logic [FLD_W-1:0] FLD_A_VAL  = 2'b11,
  parameter logic [FLD_W-1:0] FLD_B_VAL  = 2'b11
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             ctl_wr,
  input  logic [DW-1:0]    ctl_wdata,
  input  logic             cfg_wr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             ctrl_halted,
  output logic [NDOM-1:0]  dom_rst,
  output logic [FLD_W-1:0] fld_a_dflt,
  output logic [FLD_W-1:0] fld_b_dflt,
  output logic             swr_q,
  output logic             cor_q,
  output logic             csr_q,
  output logic             seq_warn
);

  src_vec_t        src_vec;
  logic [NDOM-1:0] dom_req;
  logic            swr_set_evt;

  rdc_src_regs #(
    .DW(DW), .SWR_BIT(SWR_BIT), .COR_BIT(COR_BIT), .CSR_BIT(CSR_BIT)
  ) u_regs (
    .clk         (clk),
    .hw_rst_n    (hw_rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .ctrl_halted (ctrl_halted),
    .swr_q       (swr_q),
    .cor_q       (cor_q),
    .csr_q       (csr_q),
    .swr_set_evt (swr_set_evt),
    .seq_warn    (seq_warn)
  );

  always_comb begin
    src_vec        = '0;
    src_vec[S_SWR] = swr_q;
    src_vec[S_COR] = cor_q;
    src_vec[S_CSR] = csr_q;
  end

  rdc_dom_map u_map (
    .src     (src_vec),
    .dom_req (dom_req)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_sync
    rdc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .hw_rst_n (hw_rst_n),
      .req      (dom_req[d]),
      .rst_out  (dom_rst[d])
    );
  end

  assign fld_a_dflt = FLD_A_VAL;
  assign fld_b_dflt = FLD_B_VAL;

endmodule

// File: rtl/reset_domain_ctl_chk.sv
module reset_domain_ctl_chk
  import rdc_pkg::*;
(
  input logic            clk,
  input logic            hw_rst_n,
  input logic            ctrl_halted,
  input logic            cor_q,
  input logic            csr_q,
  input logic            swr_set_evt,
  input logic            seq_warn,
  input logic [NDOM-1:0] dom_req,
  input logic [NDOM-1:0] dom_rst
);

  logic [1:0] rel_cnt;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)
      rel_cnt <= '0;
    else if (rel_cnt != 2'd3)
      rel_cnt <= rel_cnt + 2'd1;
  end

  // R5
  req_to_rst_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (dom_req != '0) |=> ((dom_rst & $past(dom_req)) == $past(dom_req)));

  // R6
  ctrl_held_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    cor_q |=> dom_rst[D_CTRL]);

  // R4
  syskeep_hw_only_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rel_cnt >= 2'd2) |-> !dom_rst[D_SYSKEEP]);

  // R4
  csr_wide_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    csr_q |=> ((dom_rst | (NDOM'(1) << D_SYSKEEP)) == '1));

  // R7
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    seq_warn |=> seq_warn);

  // R7
  warn_set_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (swr_set_evt && !cor_q && !ctrl_halted) |=> seq_warn);

  // R9
  csr_clears_cor_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
    csr_q |=> !cor_q);

endmodule

bind reset_domain_ctl reset_domain_ctl_chk u_chk (
  .clk         (clk),
  .hw_rst_n    (hw_rst_n),
  .ctrl_halted (ctrl_halted),
  .cor_q       (cor_q),
  .csr_q       (csr_q),
  .swr_set_evt (swr_set_evt),
  .seq_warn    (seq_warn),
  .dom_req     (dom_req),
  .dom_rst     (dom_rst)
);

// File: tb/reset_domain_ctl_tb.sv
`timescale 1ns/1ps
module reset_domain_ctl_tb;

  localparam int ND = 11;
  localparam logic [ND-1:0] SWR_SET = 11'b01000001100;
  localparam logic [ND-1:0] COR_SET = 11'b10000000011;
  localparam logic [ND-1:0] CSR_SET = 11'b11110111111;

  logic          clk = 1'b0;
  logic          hw_rst_n = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          ctrl_halted = 1'b0;
  logic [ND-1:0] dom_rst;
  logic [1:0]    fld_a_dflt, fld_b_dflt;
  logic          swr_q, cor_q, csr_q, seq_warn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  reset_domain_ctl u_dut (
    .clk(clk), .hw_rst_n(hw_rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ctrl_halted(ctrl_halted), .dom_rst(dom_rst),
    .fld_a_dflt(fld_a_dflt), .fld_b_dflt(fld_b_dflt),
    .swr_q(swr_q), .cor_q(cor_q), .csr_q(csr_q), .seq_warn(seq_warn)
  );

  // behavioural reference: per-domain hold counters
  bit m_swr, m_cor, m_csr, m_warn;
  int m_cnt [ND];

  function automatic logic [ND-1:0] model_out();
    logic [ND-1:0] v;
    for (int d = 0; d < ND; d++) v[d] = (m_cnt[d] > 0);
    return v;
  endfunction

  always @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      m_swr = 0; m_cor = 0; m_csr = 0; m_warn = 0;
      for (int d = 0; d < ND; d++) m_cnt[d] = 2;
    end else begin
      logic [ND-1:0] want;
      bit nswr, ncor, ncsr;
      want = (m_swr ? SWR_SET : '0) | (m_cor ? COR_SET : '0) | (m_csr ? CSR_SET : '0);
      for (int d = 0; d < ND; d++) begin
        if (want[d]) m_cnt[d] = 2;
        else if (m_cnt[d] > 0) m_cnt[d] = m_cnt[d] - 1;
      end
      if (ctl_wr && ctl_wdata[7] && !m_swr && !m_cor && !ctrl_halted) m_warn = 1;
      nswr = ctl_wr ? ctl_wdata[7] : m_swr;
      ncor = m_csr ? 1'b0 : (ctl_wr ? ctl_wdata[6] : m_cor);
      ncsr = cfg_wr ? cfg_wdata[7] : m_csr;
      m_swr = nswr; m_cor = ncor; m_csr = ncsr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison with the reference (R5 timing, R11 bits, R7 flag)
  always @(negedge clk) begin
    if (!done) begin
      chk(dom_rst == model_out(), "R5 domain levels", dom_rst, model_out());
      chk({swr_q, cor_q, csr_q} == {m_swr, m_cor, m_csr}, "R11 register bits",
          {swr_q, cor_q, csr_q}, {m_swr, m_cor, m_csr});
      chk(seq_warn == m_warn, "R7 warning flag", seq_warn, m_warn);
    end
  end

  // tasks are entered at a falling edge
  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 hw_rst_n = 1'b0;
    idle(3);
    chk(dom_rst == '1, "R1 all domains in reset", dom_rst, {ND{1'b1}});
    chk({swr_q, cor_q, csr_q, seq_warn} == 4'b0, "R1 bits cleared",
        {swr_q, cor_q, csr_q, seq_warn}, 0);
    #1 hw_rst_n = 1'b1;
    idle(3);
    chk(dom_rst == '0, "R1 released", dom_rst, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hi;
    do_reset();

    // R10
    chk(fld_a_dflt == 2'b11 && fld_b_dflt == 2'b11, "R10 field defaults",
        {fld_a_dflt, fld_b_dflt}, 4'b1111);

    // recommended order
    wr_ctl(8'h40); idle(3);
    chk(dom_rst == COR_SET, "R3 core reset domains", dom_rst, COR_SET);
    chk(cor_q == 1'b1, "R11 core bit written", cor_q, 1);
    wr_ctl(8'hC0); idle(3);
    chk(dom_rst == (COR_SET | SWR_SET), "R2 software reset domains", dom_rst, COR_SET | SWR_SET);
    chk(seq_warn == 1'b0, "R8 no warning with core held", seq_warn, 0);
    wr_ctl(8'h40); idle(3);
    chk(dom_rst == COR_SET, "R2 software domains released", dom_rst, COR_SET);
    idle(40);
    chk(dom_rst[0] == 1'b1, "R6 controller held", dom_rst[0], 1);
    wr_ctl(8'h00); idle(3);
    chk(dom_rst == '0, "R3 core domains released", dom_rst, 0);

    // halted controller: no warning
    ctrl_halted = 1'b1;
    wr_ctl(8'h80); idle(3);
    chk(dom_rst == SWR_SET, "R2 software reset alone", dom_rst, SWR_SET);
    chk(seq_warn == 1'b0, "R8 no warning when halted", seq_warn, 0);
    wr_ctl(8'h00); idle(3);
    ctrl_halted = 1'b0;

    // single-clock software reset bit
    wr_ctl(8'h80); wr_ctl(8'h00);
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      if (dom_rst[2]) hi++;
      @(negedge clk);
    end
    chk(hi == 2, "R5 minimum pulse width", hi, 2);
    chk(seq_warn == 1'b1, "R7 warning set", seq_warn, 1);
    idle(20);
    chk(seq_warn == 1'b1, "R7 warning sticky", seq_warn, 1);

    // re-raise while already set: hold value (R11)
    wr_ctl(8'h80); idle(1);
    chk(swr_q == 1'b1, "R11 software bit", swr_q, 1);
    idle(5);
    chk(swr_q == 1'b1, "R11 bit holds without strobe", swr_q, 1);
    wr_ctl(8'h00); idle(3);

    do_reset();
    chk(seq_warn == 1'b0, "R1 warning cleared by reset", seq_warn, 0);

    // card soft reset overrides core reset
    wr_ctl(8'h40); idle(2);
    wr_cfg(8'h80); idle(3);
    chk(dom_rst == CSR_SET, "R4 card reset domains", dom_rst, CSR_SET);
    chk(cor_q == 1'b0, "R9 core bit forced low", cor_q, 0);
    wr_ctl(8'h40); idle(1);
    chk(cor_q == 1'b0, "R9 core write ignored", cor_q, 0);
    wr_ctl(8'hC0); idle(1);
    chk(swr_q == 1'b1 && csr_q == 1'b1, "R9 other bits kept", {swr_q, csr_q}, 2'b11);
    chk(dom_rst[6] == 1'b0, "R4 hardware-only group untouched", dom_rst[6], 0);
    wr_ctl(8'h00);
    wr_cfg(8'h00); idle(4);
    chk(dom_rst == '0, "R4 card reset released", dom_rst, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule